// File: doc/BRIEF.md
# Submission Queue Fetch Engine

This block sits on the controller side of a host-driven command interface and follows one circular submission queue that lives in host memory. The host places 64-byte command entries into the ring and then writes the new producer index into a doorbell port. The engine keeps the consumer index (the head) to itself. Whenever the two indices differ it fetches the entry at the head over a read request/response port, splits the first 8 bytes of the entry into command fields, and offers them downstream on a valid/ready handshake. The head moves forward only after the consumer takes the entry. The current head is always shown on an output, so that completion logic can report how far the queue has been drained.

The ring size is a run-time input of up to 4096 entries. A doorbell value that does not name a slot inside the ring is dropped and raises a sticky error flag. Each fetch is a single request at `base + head*64`, answered by eight 64-bit response beats in order. Only one fetch is in flight at any time.

The controlling state machine has four states. `ST_IDLE` moves to `ST_REQ` when head and tail differ. `ST_REQ` drives the read request and moves to `ST_BEATS` once the request is accepted. `ST_BEATS` counts response beats and moves to `ST_HOLD` on the eighth. `ST_HOLD` presents the decoded command and returns to `ST_IDLE` when it is accepted, advancing the head on that same edge.

Top module: `sq_fetch_engine`

## Requirements
- R1: After reset the head reads 0, the stored tail is 0, `db_err` is 0, and neither `rd_req_valid` nor `cmd_valid` is high.
- R2: A fetch request carries the address `cfg_base + sq_head*64`. The request stays asserted with an unchanged address until `rd_req_ready` is seen high.
- R3: No new read request is raised while response beats are still owed, or while a decoded entry is waiting to be accepted.
- R4: Decoding uses only response beat 0, which holds entry bytes 7:0 in little-endian order. `cmd_opcode` is bits 7:0, `cmd_ctl` is bits 15:8, `cmd_cid` is bits 31:16 and `cmd_nsid` is bits 63:32. Beats 1 to 7 have no effect on the outputs.
- R5: `cmd_ns_none` is high exactly when the decoded namespace field is 0. `cmd_ns_all` is high exactly when that field is all ones.
- R6: While `cmd_valid` is high and `cmd_ready` is low, every command output and `sq_head` hold steady. The head changes only on the edge where a command is accepted.
- R7: The head steps by one per accepted command. After slot `cfg_qsize-1` it wraps to slot 0.
- R8: When the head equals the tail, no fetch is issued. One doorbell write that advances the tail by several slots causes all of those entries to be fetched and delivered in slot order. Several doorbell writes made before draining add up the same way.
- R9: A doorbell value at or above `cfg_qsize` leaves the tail unchanged and sets `db_err`. `db_err` then stays high until reset, and later valid doorbells still work.
- R10: While a command is offered, `sq_head` names the slot that command came from. After acceptance it names the next slot to consume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | 48 | Byte address of ring slot 0, 64-byte aligned |
| cfg_qsize | input | 13 | Number of ring slots, 2 to 4096, held stable while running |
| db_wr | input | 1 | Doorbell write strobe |
| db_value | input | 16 | New tail index written by the host |
| db_err | output | 1 | Sticky flag: an out-of-range doorbell was seen |
| rd_req_valid | output | 1 | Entry fetch request valid |
| rd_req_ready | input | 1 | Memory side accepts the request |
| rd_req_addr | output | 48 | Byte address of the entry being fetched |
| rd_rsp_valid | input | 1 | A response beat is present |
| rd_rsp_data | input | 64 | Response beat data |
| cmd_valid | output | 1 | Decoded command offered downstream |
| cmd_ready | input | 1 | Downstream accepts the command |
| cmd_opcode | output | 8 | Command opcode |
| cmd_ctl | output | 8 | Control byte of the first command word |
| cmd_cid | output | 16 | Command identifier |
| cmd_nsid | output | 32 | Namespace identifier |
| cmd_ns_none | output | 1 | Namespace field is zero |
| cmd_ns_all | output | 1 | Namespace field is all ones |
| sq_head | output | 12 | Current consumer index |

## Verification
The bench uses a five-slot ring. It feeds doorbell bursts of one to four entries over several laps, so the head wraps at every possible occupancy. A design with an off-by-one wrap would fetch from slot 5 and produce a wrong address, and one that only took a single entry per doorbell would stall with entries still pending. The bench holds `cmd_ready` low for several cycles and checks that the fields and the head do not move, which catches a head that advances at fetch time rather than at acceptance. It changes the request-ready delay and fills beats 1 to 7 with junk, which catches a decoder that latches the wrong beat or a request that is re-issued early. Out-of-range doorbells at exactly the ring size and at 0xFFFF must raise a flag that never clears and must start no fetch. The namespace values 0, all ones and ordinary values rotate so that both flags are seen set and clear.

// File: rtl/sqf_pkg.sv
package sqf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_BEATS,
        ST_HOLD
    } sqf_state_e;

    localparam int unsigned ENTRY_BYTES  = 64;
    localparam int unsigned ENTRY_SHIFT  = $clog2(ENTRY_BYTES);

    typedef struct packed {
        logic [31:0] nsid;
        logic [15:0] cid;
        logic [7:0]  ctl;
        logic [7:0]  opcode;
    } sqf_cmd_t;

endpackage

// File: rtl/sqf_doorbell.sv
module sqf_doorbell #(
    parameter int unsigned IDX_W = 12,
    parameter int unsigned DB_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W:0]   qsize,
    input  logic             db_wr,
    input  logic [DB_W-1:0]  db_value,
    output logic [IDX_W-1:0] tail,
    output logic             err
);

    localparam int unsigned PAD_W = DB_W - IDX_W - 1;

    logic in_range;

    always_comb begin
        in_range = (db_value < {{PAD_W{1'b0}}, qsize});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail <= '0;
            err  <= 1'b0;
        end else if (db_wr) begin
            if (in_range) begin
                tail <= db_value[IDX_W-1:0];
            end else begin
                err <= 1'b1;
            end
        end
    end

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R9
    tail_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (db_wr && (db_value >= {{PAD_W{1'b0}}, qsize})) |=> $stable(tail) && err);

endmodule

// File: rtl/sqf_head_ptr.sv
module sqf_head_ptr #(
    parameter int unsigned IDX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W:0]   qsize,
    input  logic             advance,
    output logic [IDX_W-1:0] head
);

    logic [IDX_W:0]   inc;
    logic [IDX_W-1:0] head_nxt;

    always_comb begin
        inc = {1'b0, head} + 1'b1;
        if (inc >= qsize) begin
            head_nxt = '0;
        end else begin
            head_nxt = inc[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
        end else if (advance) begin
            head <= head_nxt;
        end
    end

    // R7
    head_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, head} < qsize);

    // R7
    head_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && ({1'b0, head} == qsize - 1'b1)) |=> (head == '0));

endmodule

// File: rtl/sqf_entry_decode.sv
module sqf_entry_decode
    import sqf_pkg::*;
#(
    parameter int unsigned BEAT_W = 64,
    parameter int unsigned BEATS  = ENTRY_BYTES / (BEAT_W / 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              armed,
    input  logic              beat_valid,
    input  logic [BEAT_W-1:0] beat_data,
    output logic              last_beat,
    output sqf_cmd_t          fields,
    output logic              ns_none,
    output logic              ns_all
);

    localparam int unsigned CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BEATS - 1);

    logic [CNT_W-1:0] cnt;
    logic             take;

    always_comb begin
        take      = armed && beat_valid;
        last_beat = take && (cnt == LAST_IDX);
        ns_none   = (fields.nsid == '0);
        ns_all    = (fields.nsid == '1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!armed) begin
            cnt <= '0;
        end else if (take) begin
            cnt <= last_beat ? '0 : cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fields <= '0;
        end else if (take && (cnt == '0)) begin
            fields <= sqf_cmd_t'(beat_data[63:0]);
        end
    end

    // R4
    field_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (cnt != '0)) |=> $stable(fields));

endmodule

// File: rtl/sq_fetch_engine.sv
module sq_fetch_engine
    import sqf_pkg::*;
#(
    parameter int unsigned ADDR_W = 48,
    parameter int unsigned IDX_W  = 12,
    parameter int unsigned DB_W   = 16,
    parameter int unsigned BEAT_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [IDX_W:0]    cfg_qsize,
    input  logic              db_wr,
    input  logic [DB_W-1:0]   db_value,
    output logic              db_err,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ADDR_W-1:0] rd_req_addr,
    input  logic              rd_rsp_valid,
    input  logic [BEAT_W-1:0] rd_rsp_data,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [7:0]        cmd_opcode,
    output logic [7:0]        cmd_ctl,
    output logic [15:0]       cmd_cid,
    output logic [31:0]       cmd_nsid,
    output logic              cmd_ns_none,
    output logic              cmd_ns_all,
    output logic [IDX_W-1:0]  sq_head
);

    localparam int unsigned OFF_PAD = ADDR_W - IDX_W - ENTRY_SHIFT;

    sqf_state_e       state, state_nxt;
    logic [IDX_W-1:0] tail;
    logic             advance;
    logic             last_beat;
    logic             armed;
    sqf_cmd_t         fields;
    logic             ns_none, ns_all;

    sqf_doorbell #(.IDX_W(IDX_W), .DB_W(DB_W)) u_db (
        .clk      (clk),
        .rst_n    (rst_n),
        .qsize    (cfg_qsize),
        .db_wr    (db_wr),
        .db_value (db_value),
        .tail     (tail),
        .err      (db_err)
    );

    sqf_head_ptr #(.IDX_W(IDX_W)) u_head (
        .clk     (clk),
        .rst_n   (rst_n),
        .qsize   (cfg_qsize),
        .advance (advance),
        .head    (sq_head)
    );

    sqf_entry_decode #(.BEAT_W(BEAT_W)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .armed      (armed),
        .beat_valid (rd_rsp_valid),
        .beat_data  (rd_rsp_data),
        .last_beat  (last_beat),
        .fields     (fields),
        .ns_none    (ns_none),
        .ns_all     (ns_all)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (sq_head != tail) state_nxt = ST_REQ;
            ST_REQ:   if (rd_req_ready)    state_nxt = ST_BEATS;
            ST_BEATS: if (last_beat)       state_nxt = ST_HOLD;
            ST_HOLD:  if (cmd_ready)       state_nxt = ST_IDLE;
            default:                       state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rd_req_valid = (state == ST_REQ);
        armed        = (state == ST_BEATS);
        cmd_valid    = (state == ST_HOLD);
        advance      = cmd_valid && cmd_ready;
        rd_req_addr  = cfg_base + {{OFF_PAD{1'b0}}, sq_head, {ENTRY_SHIFT{1'b0}}};
        cmd_opcode   = fields.opcode;
        cmd_ctl      = fields.ctl;
        cmd_cid      = fields.cid;
        cmd_nsid     = fields.nsid;
        cmd_ns_none  = ns_none;
        cmd_ns_all   = ns_all;
    end

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

    // R3
    one_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && rd_req_ready) |=> !rd_req_valid);

    // R6
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_opcode) && $stable(cmd_cid)
                                       && $stable(cmd_nsid) && $stable(cmd_ctl)));

    // R6
    head_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_ready) |=> $stable(sq_head));

    // R8
    idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) && (sq_head == tail) && !db_wr) |=> !rd_req_valid);

endmodule

// File: tb/tb_sq_fetch_engine.sv
module tb_sq_fetch_engine;

    localparam int CLK_PERIOD = 10;
    localparam int QS         = 5;
    localparam logic [47:0] BASE = 48'h1234_5678_9000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] cfg_qsize = 13'(QS);
    logic        db_wr = 1'b0;
    logic [15:0] db_value = '0;
    logic        db_err;
    logic        rd_req_valid;
    logic        rd_req_ready = 1'b0;
    logic [47:0] rd_req_addr;
    logic        rd_rsp_valid = 1'b0;
    logic [63:0] rd_rsp_data = '0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [7:0]  cmd_opcode, cmd_ctl;
    logic [15:0] cmd_cid;
    logic [31:0] cmd_nsid;
    logic        cmd_ns_none, cmd_ns_all;
    logic [11:0] sq_head;

    always #(CLK_PERIOD/2) clk = ~clk;

    sq_fetch_engine dut (
        .clk(clk), .rst_n(rst_n), .cfg_base(BASE), .cfg_qsize(cfg_qsize),
        .db_wr(db_wr), .db_value(db_value), .db_err(db_err),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_opcode(cmd_opcode),
        .cmd_ctl(cmd_ctl), .cmd_cid(cmd_cid), .cmd_nsid(cmd_nsid),
        .cmd_ns_none(cmd_ns_none), .cmd_ns_all(cmd_ns_all), .sq_head(sq_head)
    );

    int n_chk = 0;
    int n_bad = 0;
    int exp_head = 0;
    int tail_b = 0;
    int kseq = 0;
    int req_cnt = 0;
    logic [7:0]  h_opc [QS];
    logic [15:0] h_cid [QS];
    logic [31:0] h_ns  [QS];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    function automatic logic [31:0] ns_of(input int k);
        case (k % 4)
            0:       return 32'h0;
            1:       return 32'hFFFF_FFFF;
            default: return 32'(k * 4096 + 7);
        endcase
    endfunction

    // memory responder
    initial begin
        forever begin
            @(negedge clk);
            if (rd_req_valid) begin
                int slot;
                repeat (req_cnt % 3) begin
                    @(negedge clk);
                    chk(rd_req_valid, "R2 request held", longint'(rd_req_valid), 1);
                end
                rd_req_ready = 1'b1;
                chk(rd_req_addr == BASE + 48'(exp_head * 64), "R2 fetch address",
                    longint'(rd_req_addr), longint'(BASE + 48'(exp_head * 64)));
                slot = int'((rd_req_addr - BASE) >> 6) % QS;
                req_cnt++;
                @(negedge clk);
                rd_req_ready = 1'b0;
                rd_rsp_valid = 1'b1;
                rd_rsp_data  = {h_ns[slot], h_cid[slot], 8'hA5, h_opc[slot]};
                for (int b = 1; b < 8; b++) begin
                    @(negedge clk);
                    chk(!rd_req_valid, "R3 no request during beats", longint'(rd_req_valid), 0);
                    rd_rsp_data = {32'hFFFF_FFFF, 24'hC0FFEE, 8'(b * 17)};
                end
                @(negedge clk);
                rd_rsp_valid = 1'b0;
                rd_rsp_data  = '0;
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        report();
    end

    task automatic ring(input int v);
        @(negedge clk);
        db_wr = 1'b1;
        db_value = 16'(v);
        @(negedge clk);
        db_wr = 1'b0;
    endtask

    task automatic fill(input int n);
        for (int i = 0; i < n; i++) begin
            h_opc[tail_b] = 8'(kseq * 37 + 5);
            h_cid[tail_b] = 16'(kseq * 257 + 3);
            h_ns[tail_b]  = ns_of(kseq);
            kseq++;
            tail_b = (tail_b + 1) % QS;
        end
    endtask

    task automatic consume(input int stall);
        int w = 0;
        while (!cmd_valid && w < 300) begin
            @(negedge clk);
            w++;
        end
        chk(cmd_valid, "R8 entry delivered", longint'(cmd_valid), 1);
        chk(cmd_opcode == h_opc[exp_head], "R4 opcode", cmd_opcode, h_opc[exp_head]);
        chk(cmd_cid == h_cid[exp_head], "R4 cid", cmd_cid, h_cid[exp_head]);
        chk(cmd_nsid == h_ns[exp_head], "R4 nsid", cmd_nsid, h_ns[exp_head]);
        chk(cmd_ctl == 8'hA5, "R4 control byte", cmd_ctl, 8'hA5);
        chk(cmd_ns_none == (h_ns[exp_head] == 0), "R5 none flag", cmd_ns_none, h_ns[exp_head] == 0);
        chk(cmd_ns_all == (h_ns[exp_head] == 32'hFFFF_FFFF), "R5 all flag", cmd_ns_all,
            h_ns[exp_head] == 32'hFFFF_FFFF);
        chk(sq_head == 12'(exp_head), "R10 head names offered slot", sq_head, exp_head);
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            chk(cmd_valid && cmd_cid == h_cid[exp_head] && sq_head == 12'(exp_head),
                "R6 stall holds", sq_head, exp_head);
        end
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        exp_head = (exp_head + 1) % QS;
        chk(sq_head == 12'(exp_head), "R7 head step and wrap", sq_head, exp_head);
    endtask

    task automatic quiet(input int cyc, input string tag);
        bit seen = 1'b0;
        for (int c = 0; c < cyc; c++) begin
            @(negedge clk);
            if (rd_req_valid || cmd_valid) seen = 1'b1;
        end
        chk(!seen, tag, longint'(seen), 0);
    endtask

    initial begin
        int pat [8] = '{1, 3, 2, 4, 1, 4, 2, 3};
        repeat (4) @(negedge clk);
        // R1 reset values
        chk(sq_head == 0, "R1 head", sq_head, 0);
        chk(!rd_req_valid && !cmd_valid, "R1 no activity", longint'({rd_req_valid, cmd_valid}), 0);
        chk(!db_err, "R1 err clear", longint'(db_err), 0);
        rst_n = 1'b1;
        quiet(8, "R1 R8 empty after reset");

        // bursts of every size, several laps
        for (int r = 0; r < 8; r++) begin
            fill(pat[r]);
            ring(tail_b);
            for (int i = 0; i < pat[r]; i++) consume((r + i) % 4);
            quiet(6, "R8 idle when drained");
        end
        chk(!db_err, "R9 no error on valid doorbells", longint'(db_err), 0);

        // two doorbells accumulate before draining
        fill(2); ring(tail_b);
        fill(2); ring(tail_b);
        for (int i = 0; i < 4; i++) consume(1);
        quiet(6, "R8 idle after stacked doorbells");

        // out-of-range doorbells
        ring(QS);
        chk(db_err, "R9 err at qsize", longint'(db_err), 1);
        quiet(12, "R9 ignored doorbell starts nothing");
        chk(sq_head == 12'(exp_head), "R9 head unchanged", sq_head, exp_head);
        ring(16'hFFFF);
        quiet(8, "R9 ignored large doorbell");
        fill(3); ring(tail_b);
        for (int i = 0; i < 3; i++) consume(2);
        chk(db_err, "R9 err sticky", longint'(db_err), 1);
        quiet(6, "R8 idle at end");
        report();
    end

endmodule